// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Per-Port Read Latency Choice

This block is a true two-port synchronous memory. Port A and port B each have their own clock, address, write data, read data, a read/write strobe, an active-low and an active-high chip enable, a low-lane and a high-lane byte select, an output enable and a latency-select pin. Either port may read or write any word at any time, independently of the other port. The data word is split into two equal byte lanes. Writes change only the lanes that are selected. Reads show only the lanes that are selected and enabled for output.

Each port picks its read latency with its own latency-select pin. With the pin low (flow-through), the data for an address taken at a rising edge appears right after that edge. With the pin high (pipelined), a second register adds one cycle. Output enable works at once, with no clock, as a gate on the per-lane valid flags. A tri-stated lane is modelled as a cleared valid bit and zero data.

Each port has a small state machine that holds the operation taken at the last edge. Its states are `OP_IDLE` (deselected), `OP_READ` and `OP_WRITE`. At every rising edge the machine moves to one of these states:
- **deselect**: to `OP_IDLE` when the port is not selected.
- **read**: to `OP_READ` when the port is selected with the strobe high.
- **write**: to `OP_WRITE` when the port is selected with the strobe low.

In pipelined mode a second stage holds the state from one edge earlier, and the outputs follow that stage.

Top module: `dpr_dual_latency`

## Requirements
- R1: A port is selected only when its active-low enable is 0 and its active-high enable is 1. Any other pair of values means no write, and the port's valid flags are cleared for that cycle's result.
- R2: Inputs are taken at the rising edge of the port's clock. Strobe 0 means write and strobe 1 means read.
- R3: A write changes only the lanes whose select is 0. The low lane is bits [DATA_W/2-1:0] with select `lb_n`, and the high lane is the upper half with select `ub_n`. A lane that is not selected keeps its old contents.
- R4: Read-valid bit 0 (low lane) or bit 1 (high lane) is 1 only for a read whose lane select was 0, while output enable is 0. A lane that is not driven reads as zero.
- R5: With the latency pin at 0, read data for an address taken at edge N is on the outputs from edge N until edge N+1.
- R6: With the latency pin at 1, the same data appears one cycle later, from edge N+1.
- R7: Output enable (active low) gates the valid flags and the data at once, with no clock edge.
- R8: In pipelined mode, a select or deselect reaches the outputs one cycle later than in flow-through mode.
- R9: A port that reads a word in the same cycle as the other port writes it gets the old contents. A later read gets the new contents.
- R10: A word written through either port can be read through the other port.
- R11: After reset, both ports show no valid lanes and zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| b_clk | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output stages |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rw | input | 1 | Port A strobe: 1 read, 0 write |
| a_ce0_n | input | 1 | Port A enable, active low |
| a_ce1 | input | 1 | Port A enable, active high |
| a_lb_n | input | 1 | Port A low-lane select, active low |
| a_ub_n | input | 1 | Port A high-lane select, active low |
| a_oe_n | input | 1 | Port A output enable, active low, not clocked |
| a_pipe | input | 1 | Port A latency select: 0 flow-through, 1 pipelined |
| a_dout | output | DATA_W | Port A read data |
| a_dout_vld | output | 2 | Port A per-lane valid (bit 0 low lane) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rw | input | 1 | Port B strobe: 1 read, 0 write |
| b_ce0_n | input | 1 | Port B enable, active low |
| b_ce1 | input | 1 | Port B enable, active high |
| b_lb_n | input | 1 | Port B low-lane select, active low |
| b_ub_n | input | 1 | Port B high-lane select, active low |
| b_oe_n | input | 1 | Port B output enable, active low, not clocked |
| b_pipe | input | 1 | Port B latency select: 0 flow-through, 1 pipelined |
| b_dout | output | DATA_W | Port B read data |
| b_dout_vld | output | 2 | Port B per-lane valid (bit 0 low lane) |

## Verification
Some properties hold on every cycle, and the embedded assertions check these:
- A write or a deselect in flow-through mode leaves no valid lane after the next edge.
- A read with its lane selected shows that lane as valid one edge later in flow-through mode, or two edges later in pipelined mode.
- A deasserted output enable clears every valid flag.

Other properties depend on the data held in the memory, so only the bench scenarios can show them:
- Lane masking on writes.
- Data written through one port and read through the other.
- A read that collides with a write from the other port returning old data.
- Immediate output-enable gating between clock edges, which the bench checks with a scoreboard.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
    localparam int LANES = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;
endpackage

// File: rtl/dpr_bank.sv
`timescale 1ns/1ps
// Storage written by a single port. Each lane keeps a flag. Bank 0 copies
// the peer flag and bank 1 stores its inverse, so comparing the two flags
// tells which bank holds the newest lane.
module dpr_bank #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 18,
    parameter int PEER_INV = 0
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [1:0]        wr_lanes,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        peer_flag,
    input  logic [ADDR_W-1:0] rd_addr0,
    input  logic [ADDR_W-1:0] rd_addr1,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1,
    output logic [1:0]        rd_flag0,
    output logic [1:0]        rd_flag1
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / 2;
    localparam logic INV  = (PEER_INV != 0);

    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic [LANE_W-1:0] lane_mem  [DEPTH];
        logic              lane_flag [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[l]) begin
                lane_mem[wr_addr]  <= wr_data[l*LANE_W +: LANE_W];
                lane_flag[wr_addr] <= peer_flag[l] ^ INV;
            end
        end

        assign rd_data0[l*LANE_W +: LANE_W] = lane_mem[rd_addr0];
        assign rd_data1[l*LANE_W +: LANE_W] = lane_mem[rd_addr1];
        assign rd_flag0[l] = lane_flag[rd_addr0];
        assign rd_flag1[l] = lane_flag[rd_addr1];
    end
endmodule

// File: rtl/dpr_port.sv
`timescale 1ns/1ps
// Per-port control: decodes the select, registers the operation state and
// the read word, adds an optional second stage, and gates the outputs.
module dpr_port
    import dpr_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              rw,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic              oe_n,
    input  logic              pipe_mode,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_en,
    output logic [1:0]        wr_lanes,
    output logic [DATA_W-1:0] dout,
    output logic [1:0]        dout_vld
);
    localparam int LANE_W = DATA_W / 2;

    port_op_e          op_nxt, op_s1, op_s2, op_out;
    logic              selected;
    logic [1:0]        lanes_in, lanes_s1, lanes_s2, lanes_out;
    logic [DATA_W-1:0] data_s1, data_s2, data_out;

    // Next-state decode.
    always_comb begin
        selected = !ce0_n && ce1;
        lanes_in = {~ub_n, ~lb_n};
        if (!selected) begin
            op_nxt = OP_IDLE;
        end else if (rw) begin
            op_nxt = OP_READ;
        end else begin
            op_nxt = OP_WRITE;
        end
    end

    assign wr_en    = (op_nxt == OP_WRITE);
    assign wr_lanes = lanes_in;

    // State registers: stage 1 and the pipelined stage 2.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_s1    <= OP_IDLE;
            op_s2    <= OP_IDLE;
            lanes_s1 <= '0;
            lanes_s2 <= '0;
            data_s1  <= '0;
            data_s2  <= '0;
        end else begin
            op_s1    <= op_nxt;
            lanes_s1 <= lanes_in;
            data_s1  <= rd_word;
            op_s2    <= op_s1;
            lanes_s2 <= lanes_s1;
            data_s2  <= data_s1;
        end
    end

    // Output process.
    always_comb begin
        op_out    = pipe_mode ? op_s2 : op_s1;
        lanes_out = pipe_mode ? lanes_s2 : lanes_s1;
        data_out  = pipe_mode ? data_s2 : data_s1;
        dout_vld  = '0;
        dout      = '0;
        unique case (op_out)
            OP_READ: begin
                dout_vld = lanes_out & {2{~oe_n}};
                for (int l = 0; l < 2; l++) begin
                    if (dout_vld[l]) begin
                        dout[l*LANE_W +: LANE_W] = data_out[l*LANE_W +: LANE_W];
                    end
                end
            end
            OP_IDLE, OP_WRITE: begin
                dout_vld = '0;
            end
            default: begin
                dout_vld = '0;
            end
        endcase
    end

    assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!ce0_n && ce1) && !pipe_mode) |=> (pipe_mode || dout_vld == 2'b00));

    assert_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce0_n && ce1 && !rw && !pipe_mode) |=> (pipe_mode || dout_vld == 2'b00));

    assert_flow_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce0_n && ce1 && rw && !lb_n && !pipe_mode) |=> (pipe_mode || oe_n || dout_vld[0]));

    assert_pipe_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(pipe_mode) && !oe_n && $past(!ce0_n && ce1 && rw && !ub_n, 2))
        |-> dout_vld[1]);

    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (dout_vld == 2'b00 && dout == '0));
endmodule

// File: rtl/dpr_dual_latency.sv
`timescale 1ns/1ps
module dpr_dual_latency
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              a_clk,
    input  logic              b_clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_rw,
    input  logic              a_ce0_n,
    input  logic              a_ce1,
    input  logic              a_lb_n,
    input  logic              a_ub_n,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    output logic [DATA_W-1:0] a_dout,
    output logic [1:0]        a_dout_vld,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_rw,
    input  logic              b_ce0_n,
    input  logic              b_ce1,
    input  logic              b_lb_n,
    input  logic              b_ub_n,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    output logic [DATA_W-1:0] b_dout,
    output logic [1:0]        b_dout_vld
);
    localparam int LANE_W = DATA_W / 2;

    logic              p_clk   [LANES];
    logic [ADDR_W-1:0] p_addr  [LANES];
    logic [DATA_W-1:0] p_wdata [LANES];
    logic              p_rw    [LANES];
    logic              p_ce0_n [LANES];
    logic              p_ce1   [LANES];
    logic              p_lb_n  [LANES];
    logic              p_ub_n  [LANES];
    logic              p_oe_n  [LANES];
    logic              p_pipe  [LANES];
    logic [DATA_W-1:0] p_dout  [LANES];
    logic [1:0]        p_vld   [LANES];
    logic              p_we    [LANES];
    logic [1:0]        p_wl    [LANES];
    logic [DATA_W-1:0] merged  [LANES];
    logic [DATA_W-1:0] bk_data [LANES][LANES];
    logic [1:0]        bk_flag [LANES][LANES];

    assign p_clk[0]   = a_clk;    assign p_clk[1]   = b_clk;
    assign p_addr[0]  = a_addr;   assign p_addr[1]  = b_addr;
    assign p_wdata[0] = a_wdata;  assign p_wdata[1] = b_wdata;
    assign p_rw[0]    = a_rw;     assign p_rw[1]    = b_rw;
    assign p_ce0_n[0] = a_ce0_n;  assign p_ce0_n[1] = b_ce0_n;
    assign p_ce1[0]   = a_ce1;    assign p_ce1[1]   = b_ce1;
    assign p_lb_n[0]  = a_lb_n;   assign p_lb_n[1]  = b_lb_n;
    assign p_ub_n[0]  = a_ub_n;   assign p_ub_n[1]  = b_ub_n;
    assign p_oe_n[0]  = a_oe_n;   assign p_oe_n[1]  = b_oe_n;
    assign p_pipe[0]  = a_pipe;   assign p_pipe[1]  = b_pipe;
    assign a_dout     = p_dout[0];
    assign a_dout_vld = p_vld[0];
    assign b_dout     = p_dout[1];
    assign b_dout_vld = p_vld[1];

    for (genvar p = 0; p < LANES; p++) begin : g_port
        dpr_port #(.DATA_W(DATA_W)) u_port (
            .clk      (p_clk[p]),
            .rst_n    (rst_n),
            .ce0_n    (p_ce0_n[p]),
            .ce1      (p_ce1[p]),
            .rw       (p_rw[p]),
            .lb_n     (p_lb_n[p]),
            .ub_n     (p_ub_n[p]),
            .oe_n     (p_oe_n[p]),
            .pipe_mode(p_pipe[p]),
            .rd_word  (merged[p]),
            .wr_en    (p_we[p]),
            .wr_lanes (p_wl[p]),
            .dout     (p_dout[p]),
            .dout_vld (p_vld[p])
        );

        dpr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PEER_INV(p)) u_bank (
            .clk      (p_clk[p]),
            .wr_en    (p_we[p]),
            .wr_lanes (p_wl[p]),
            .wr_addr  (p_addr[p]),
            .wr_data  (p_wdata[p]),
            .peer_flag(bk_flag[1-p][p]),
            .rd_addr0 (p_addr[0]),
            .rd_addr1 (p_addr[1]),
            .rd_data0 (bk_data[p][0]),
            .rd_data1 (bk_data[p][1]),
            .rd_flag0 (bk_flag[p][0]),
            .rd_flag1 (bk_flag[p][1])
        );

        // Equal flags mean bank 0 wrote the lane last.
        for (genvar l = 0; l < 2; l++) begin : g_merge
            assign merged[p][l*LANE_W +: LANE_W] =
                (bk_flag[0][p][l] == bk_flag[1][p][l]) ? bk_data[0][p][l*LANE_W +: LANE_W]
                                                       : bk_data[1][p][l*LANE_W +: LANE_W];
        end
    end
endmodule

// File: tb/dpr_dual_latency_tb_top.sv
`timescale 1ns/1ps
module dpr_dual_latency_tb_top;
    localparam int AW = 10;
    localparam int DW = 18;
    localparam int LW = DW / 2;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic rw, ce0_n, ce1, lb_n, ub_n, oe_n, mode;
    } pin_t;

    typedef struct packed {
        logic          rd;
        logic [1:0]    ln;
        logic [DW-1:0] d;
    } ent_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    pin_t cur [2];
    ent_t h1 [2];
    ent_t h2 [2];
    logic [DW-1:0] mdl [32];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string phase_tag = "";

    logic [DW-1:0] a_dout, b_dout;
    logic [1:0]    a_vld, b_vld;

    dpr_dual_latency #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .a_clk(clk), .b_clk(clk), .rst_n(rst_n),
        .a_addr(cur[0].addr), .a_wdata(cur[0].wd), .a_rw(cur[0].rw),
        .a_ce0_n(cur[0].ce0_n), .a_ce1(cur[0].ce1), .a_lb_n(cur[0].lb_n),
        .a_ub_n(cur[0].ub_n), .a_oe_n(cur[0].oe_n), .a_pipe(cur[0].mode),
        .a_dout(a_dout), .a_dout_vld(a_vld),
        .b_addr(cur[1].addr), .b_wdata(cur[1].wd), .b_rw(cur[1].rw),
        .b_ce0_n(cur[1].ce0_n), .b_ce1(cur[1].ce1), .b_lb_n(cur[1].lb_n),
        .b_ub_n(cur[1].ub_n), .b_oe_n(cur[1].oe_n), .b_pipe(cur[1].mode),
        .b_dout(b_dout), .b_dout_vld(b_vld)
    );

    function automatic pin_t idle(logic mode);
        pin_t p;
        p = '0;
        p.rw = 1'b1; p.ce0_n = 1'b1; p.ce1 = 1'b0;
        p.lb_n = 1'b1; p.ub_n = 1'b1; p.oe_n = 1'b0; p.mode = mode;
        return p;
    endfunction

    function automatic pin_t mk(int a, logic [DW-1:0] wd, logic rw, logic lb_n,
                                logic ub_n, logic oe_n, logic mode);
        pin_t p;
        p.addr = AW'(a); p.wd = wd; p.rw = rw; p.ce0_n = 1'b0; p.ce1 = 1'b1;
        p.lb_n = lb_n; p.ub_n = ub_n; p.oe_n = oe_n; p.mode = mode;
        return p;
    endfunction

    function automatic bit is_sel(pin_t p);
        return !p.ce0_n && p.ce1;
    endfunction

    function automatic ent_t predict(pin_t p);
        ent_t e;
        e.rd = is_sel(p) && p.rw;
        e.ln = {~p.ub_n, ~p.lb_n};
        e.d  = mdl[p.addr[4:0]];
        return e;
    endfunction

    function automatic logic [1:0] exp_vld(ent_t e, logic oe_n);
        return e.rd ? (e.ln & {2{~oe_n}}) : 2'b00;
    endfunction

    function automatic logic [DW-1:0] exp_dout(ent_t e, logic oe_n);
        logic [1:0] v;
        logic [DW-1:0] d;
        v = exp_vld(e, oe_n);
        d = '0;
        if (v[0]) d[LW-1:0]  = e.d[LW-1:0];
        if (v[1]) d[DW-1:LW] = e.d[DW-1:LW];
        return d;
    endfunction

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_port(int p);
        ent_t e;
        string tag;
        logic [DW-1:0] ad;
        logic [1:0] av;
        e   = cur[p].mode ? h2[p] : h1[p];
        tag = (phase_tag != "") ? phase_tag : (cur[p].mode ? "R6" : "R5");
        ad  = (p == 0) ? a_dout : b_dout;
        av  = (p == 0) ? a_vld : b_vld;
        chk(tag, (p == 0) ? "port A valid" : "port B valid", DW'(av), DW'(exp_vld(e, cur[p].oe_n)));
        chk(tag, (p == 0) ? "port A data" : "port B data", ad, exp_dout(e, cur[p].oe_n));
    endtask

    task automatic apply_write(pin_t p);
        if (is_sel(p) && !p.rw) begin
            if (!p.lb_n) mdl[p.addr[4:0]][LW-1:0]  = p.wd[LW-1:0];
            if (!p.ub_n) mdl[p.addr[4:0]][DW-1:LW] = p.wd[DW-1:LW];
        end
    endtask

    task automatic step(pin_t na, pin_t nb);
        ent_t ea, eb;
        @(negedge clk);
        check_port(0);
        check_port(1);
        if (is_sel(na) && is_sel(nb) && !na.rw && !nb.rw && na.addr == nb.addr) nb.rw = 1'b1;
        cur[0] = na;
        cur[1] = nb;
        ea = predict(na);
        eb = predict(nb);
        apply_write(na);
        apply_write(nb);
        h2[0] = h1[0]; h1[0] = ea;
        h2[1] = h1[1]; h1[1] = eb;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        pin_t ra, rb;
        void'($urandom(32'h5eed_0017));
        cur[0] = idle(1'b0); cur[1] = idle(1'b0);
        h1[0] = '0; h1[1] = '0; h2[0] = '0; h2[1] = '0;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: nothing valid while and right after reset.
        chk("R11", "port A valid", DW'(a_vld), '0);
        chk("R11", "port B valid", DW'(b_vld), '0);
        chk("R11", "port A data", a_dout, '0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11", "port B data after release", b_dout, '0);

        // R2: preload every test word with full writes from port A.
        phase_tag = "R2";
        for (int a = 0; a < 32; a++)
            step(mk(a, DW'((a * 37) ^ 18'h2a5a5), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), idle(1'b0));
        step(mk(5, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0), idle(1'b0));

        // R10: write through one port, read through the other.
        phase_tag = "R10";
        step(mk(3, 18'h1c3c3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), idle(1'b0));
        step(idle(1'b0), mk(3, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        step(idle(1'b0), mk(4, 18'h0beef, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        step(mk(4, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0), idle(1'b0));
        step(idle(1'b0), idle(1'b0));

        // R9: same-cycle read of a word being written returns old data.
        phase_tag = "R9";
        step(mk(7, 18'h33333, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), mk(7, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        step(idle(1'b0), mk(7, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        step(idle(1'b0), idle(1'b0));

        // R3: low-lane-only write keeps the high lane.
        phase_tag = "R3";
        step(mk(9, 18'h3ffff, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0), idle(1'b0));
        step(mk(9, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0), idle(1'b0));
        step(idle(1'b0), idle(1'b0));

        // R4: unselected lane and disabled output are not driven.
        phase_tag = "R4";
        step(mk(9, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0), mk(9, '0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
        step(idle(1'b0), idle(1'b0));

        // R1: writes with a deselecting enable pair change nothing.
        phase_tag = "R1";
        ra = mk(10, 18'h15555, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); ra.ce0_n = 1'b1;
        step(ra, idle(1'b0));
        ra.ce0_n = 1'b0; ra.ce1 = 1'b0;
        step(ra, idle(1'b0));
        step(mk(10, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0), idle(1'b0));
        step(idle(1'b0), idle(1'b0));

        // R7: output enable acts between clock edges.
        phase_tag = "R7";
        step(mk(11, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0), idle(1'b0));
        @(posedge clk); #1;
        chk("R7", "valid before oe", DW'(a_vld), DW'(2'b11));
        cur[0].oe_n = 1'b1; #0.2;
        chk("R7", "valid with oe off", DW'(a_vld), '0);
        chk("R7", "data with oe off", a_dout, '0);
        cur[0].oe_n = 1'b0; #0.2;
        chk("R7", "data with oe back", a_dout, mdl[11]);
        step(idle(1'b0), idle(1'b0));

        // R8: pipelined select/deselect lag one extra cycle.
        phase_tag = "R8";
        step(mk(12, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1), idle(1'b1));
        step(idle(1'b1), idle(1'b1));
        step(mk(13, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1), mk(13, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
        step(idle(1'b1), idle(1'b1));
        step(idle(1'b1), idle(1'b1));
        step(idle(1'b0), idle(1'b0));
        step(idle(1'b0), idle(1'b0));

        // R5/R6: random traffic, latency mode changes per segment.
        phase_tag = "";
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < 2; p++) begin
                pin_t q;
                q.addr  = AW'($urandom_range(0, 31));
                q.wd    = DW'($urandom);
                q.rw    = $urandom_range(0, 1) != 0;
                q.ce0_n = $urandom_range(0, 9) == 0;
                q.ce1   = $urandom_range(0, 9) != 0;
                q.lb_n  = $urandom_range(0, 3) == 0;
                q.ub_n  = $urandom_range(0, 3) == 0;
                q.oe_n  = $urandom_range(0, 9) == 0;
                q.mode  = (i % 64 == 0) ? ($urandom_range(0, 1) != 0) : cur[p].mode;
                if (p == 0) ra = q; else rb = q;
            end
            step(ra, rb);
        end
        step(idle(1'b0), idle(1'b0));
        step(idle(1'b0), idle(1'b0));
        finish_run();
    end
endmodule